// File: doc/BRIEF.md
# DMA Request-to-Channel Mapper

This block sits between the peripheral request lines of a chip and its DMA channels. Each of 75 request inputs has its own 8-bit routing entry. The entry names the target channel and carries a valid flag. For every channel, the block reports the combined request level. It also raises a one-cycle event when that level starts and a one-cycle event when it ends. The interrupt logic and the transfer engine consume these outputs. Neither is part of this block.

Software programs the routing table through a simple 32-bit register port. Entries 0 to 63 sit in a low window and entries 64 to 74 sit in a separate high window. Three request-status words are kept only for address compatibility: they read as zero and ignore writes. A write is flagged when it carries an invalid mapping, that is, a channel number at or above the configured channel limit, or nonzero reserved bits. The entry is stored anyway.

Top module: `dma_req_mapper`

## Requirements
- R1: After reset every routing entry is zero and `chReq`, `chRasEvt`, `chEorEvt`, `mapErr` and `rdData` are all zero.
- R2: A write to byte address 0x0100 + 4*i (i = 0..63) stores `wrData[7:0]` as entry i. A read of that address returns the entry in `rdData[7:0]` with the upper bits zero, valid after the clock edge that samples `rdEn`. `rdData` holds its value while `rdEn` is low.
- R3: Entry 64 + j (j = 0..10) is written and read at byte address 0x1100 + 4*j, with the same data layout as R2.
- R4: Entry bit 7 marks the entry valid and bits 4:0 give the channel. When request r rises on a valid entry, `chReq[channel]` goes high two clock edges later: one edge samples the input and one registers the channel level.
- R5: A request whose entry has bit 7 clear has no effect on any channel output, even when its channel bits are nonzero.
- R6: When several valid entries name the same channel, that channel's level is the OR of their requests. Dropping one of them while another stays high neither clears the level nor produces an end event.
- R7: `chRasEvt[c]` pulses for exactly one cycle, in the same cycle that `chReq[c]` goes from 0 to 1. It does not pulse when a further request joins a channel that is already high.
- R8: `chEorEvt[c]` pulses for exactly one cycle, in the cycle after the edge where `chReq[c]` goes from 1 to 0.
- R9: Byte addresses 0x00E0, 0x00E4 and 0x00E8, and any other address outside the two windows, read as zero. Writes to them change no routing entry.
- R10: `mapErr` is high for the one cycle after a table write in two cases. The first is when bit 7 is set and bits 4:0 are at or above `CH_LIMIT` (default 24). The second is when `wrData[31:8]` is nonzero. The low byte is still stored and routes as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 16 | Byte address of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| mapErr | output | 1 | One-cycle flag for an invalid table write |
| reqIn | input | 75 | Peripheral request levels |
| chReq | output | 32 | Combined request level per channel |
| chRasEvt | output | 32 | One-cycle pulse when a channel level starts |
| chEorEvt | output | 32 | One-cycle pulse when a channel level ends |

## Verification
The hardest case to reach from the ports is a channel fed by two requests from different table windows, with staggered edges. The level must stay up, and no start or end event may appear, while only one of the two requests changes. The bench reaches it by mapping entries 1 and 66 to one channel and raising them one after the other. It then lowers them one at a time, checking at each step that no event appears until the last request falls. A table of vectors also covers both window boundaries, an invalid entry that has channel bits set, and an over-limit entry that must still route.

// File: rtl/dmamap_pkg.sv
package dmamap_pkg;
  localparam int REQ_CNT_DEF = 75;
  localparam int CH_CNT_DEF  = 32;
  localparam int IDX_W       = 7;
  localparam int VALID_BIT   = 7;

  // strobes from register control to the table datapath
  typedef struct packed {
    logic             mapWr;
    logic [IDX_W-1:0] mapIdx;
    logic [7:0]       wrVal;
  } mapStb_t;
endpackage

// File: rtl/dmamap_ctl.sv
module dmamap_ctl
  import dmamap_pkg::*;
#(
  parameter int          REQ_CNT  = REQ_CNT_DEF,
  parameter int          LO_CNT   = 64,
  parameter int          CH_LIMIT = 24,
  parameter logic [15:0] LO_BASE  = 16'h0100,
  parameter logic [15:0] HI_BASE  = 16'h1100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [15:0] addr,
  input  logic [31:0] wrData,
  input  logic [7:0]  mapRdVal,
  output mapStb_t     stb,
  output logic [31:0] rdData,
  output logic        mapErr
);
  localparam int          HI_CNT  = REQ_CNT - LO_CNT;
  localparam logic [16:0] LO_END  = 17'(int'(LO_BASE) + 4 * LO_CNT);
  localparam logic [16:0] HI_END  = 17'(int'(HI_BASE) + 4 * HI_CNT);
  localparam logic [5:0]  LIMIT_V = 6'(CH_LIMIT);

  logic        aligned, loHit, hiHit, hit, badWr;
  logic [15:0] loOff, hiOff;
  logic [IDX_W-1:0] idx;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    loHit   = aligned && (addr >= LO_BASE) && ({1'b0, addr} < LO_END);
    hiHit   = aligned && (addr >= HI_BASE) && ({1'b0, addr} < HI_END);
    hit     = loHit || hiHit;
    loOff   = addr - LO_BASE;
    hiOff   = addr - HI_BASE;
    if (hiHit) idx = IDX_W'(LO_CNT) + hiOff[IDX_W+1:2];
    else       idx = loOff[IDX_W+1:2];
    stb.mapWr  = wrEn && hit;
    stb.mapIdx = idx;
    stb.wrVal  = wrData[7:0];
    badWr = stb.mapWr &&
            ((wrData[VALID_BIT] && ({1'b0, wrData[4:0]} >= LIMIT_V)) ||
             (wrData[31:8] != 24'h0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      mapErr <= 1'b0;
    end else begin
      mapErr <= badWr;
      if (rdEn) rdData <= hit ? {24'h0, mapRdVal} : 32'h0;
    end
  end

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    mapErr |-> $past(wrEn));  // R10
  AST_STATUS_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == 16'h00E0 || addr == 16'h00E4 || addr == 16'h00E8))
      |=> (rdData == 32'h0));  // R9
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));  // R2
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:8] == 24'h0);  // R2
endmodule

// File: rtl/dmamap_dp.sv
module dmamap_dp
  import dmamap_pkg::*;
#(
  parameter int REQ_CNT = REQ_CNT_DEF,
  parameter int CH_CNT  = CH_CNT_DEF
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapStb_t            stb,
  input  logic [REQ_CNT-1:0] reqIn,
  output logic [7:0]         mapRdVal,
  output logic [CH_CNT-1:0]  chReq,
  output logic [CH_CNT-1:0]  chRasEvt,
  output logic [CH_CNT-1:0]  chEorEvt
);
  logic [7:0]         mapTab [REQ_CNT];
  logic [REQ_CNT-1:0] reqQ;
  logic [CH_CNT-1:0]  lvlNext, lvlQ, rasQ, eorQ;

  // routing table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REQ_CNT; i++) mapTab[i] <= 8'h0;
    end else if (stb.mapWr && (int'(stb.mapIdx) < REQ_CNT)) begin
      mapTab[stb.mapIdx] <= stb.wrVal;
    end
  end

  always_comb begin
    if (int'(stb.mapIdx) < REQ_CNT) mapRdVal = mapTab[stb.mapIdx];
    else                            mapRdVal = 8'h0;
  end

  // per-channel OR of every valid request routed to it
  for (genvar c = 0; c < CH_CNT; c++) begin : g_ch
    logic anyHit;
    always_comb begin
      anyHit = 1'b0;
      for (int r = 0; r < REQ_CNT; r++) begin
        if (mapTab[r][VALID_BIT] && (mapTab[r][4:0] == 5'(c)) && reqQ[r])
          anyHit = 1'b1;
      end
    end
    assign lvlNext[c] = anyHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ <= '0;
      lvlQ <= '0;
      rasQ <= '0;
      eorQ <= '0;
    end else begin
      reqQ <= reqIn;
      lvlQ <= lvlNext;
      rasQ <= lvlNext & ~lvlQ;
      eorQ <= ~lvlNext & lvlQ;
    end
  end

  assign chReq    = lvlQ;
  assign chRasEvt = rasQ;
  assign chEorEvt = eorQ;

  AST_RAS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (rasQ & $past(rasQ)) == '0);  // R7
  AST_EOR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (eorQ & $past(eorQ)) == '0);  // R8
  AST_RAS_WITH_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (rasQ & ~lvlQ) == '0);  // R7
  AST_EOR_WITHOUT_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (eorQ & lvlQ) == '0);  // R8
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (rasQ & eorQ) == '0);  // R7
endmodule

// File: rtl/dma_req_mapper.sv
module dma_req_mapper
  import dmamap_pkg::*;
#(
  parameter int REQ_CNT  = REQ_CNT_DEF,
  parameter int CH_CNT   = CH_CNT_DEF,
  parameter int CH_LIMIT = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [15:0]        addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               mapErr,
  input  logic [REQ_CNT-1:0] reqIn,
  output logic [CH_CNT-1:0]  chReq,
  output logic [CH_CNT-1:0]  chRasEvt,
  output logic [CH_CNT-1:0]  chEorEvt
);
  mapStb_t    stb;
  logic [7:0] mapRdVal;

  dmamap_ctl #(.REQ_CNT(REQ_CNT), .CH_LIMIT(CH_LIMIT)) i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .mapRdVal(mapRdVal), .stb(stb),
    .rdData(rdData), .mapErr(mapErr)
  );

  dmamap_dp #(.REQ_CNT(REQ_CNT), .CH_CNT(CH_CNT)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqIn(reqIn),
    .mapRdVal(mapRdVal), .chReq(chReq),
    .chRasEvt(chRasEvt), .chEorEvt(chEorEvt)
  );
endmodule

// File: tb/test_dma_req_mapper.sv
module test_dma_req_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        mapErr;
  logic [74:0] reqIn = '0;
  logic [31:0] chReq, chRasEvt, chEorEvt;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_req_mapper i_dma_req_mapper (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .mapErr(mapErr), .reqIn(reqIn),
    .chReq(chReq), .chRasEvt(chRasEvt), .chEorEvt(chEorEvt)
  );

  // [14:8] entry index, [7:0] entry value
  localparam logic [15:0] VEC [9] = '{
    16'h0083, 16'h3F9F, 16'h4080, 16'h4A91, 16'h0A03,
    16'h2897, 16'h058C, 16'h4605, 16'h329B
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] entAddr(input int idx);
    return (idx < 64) ? 16'(16'h0100 + 4 * idx) : 16'(16'h1100 + 4 * (idx - 64));
  endfunction

  task automatic busWr(input logic [15:0] a, input logic [31:0] d, output logic err);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    err = mapErr;
  endtask

  task automatic busRd(input logic [15:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic err;
    waitN(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 chReq", chReq, 32'h0);
    chk("R1 chRasEvt", chRasEvt, 32'h0);
    chk("R1 chEorEvt", chEorEvt, 32'h0);
    chk("R1 mapErr", {31'h0, mapErr}, 32'h0);
    busRd(16'h0100, v);
    chk("R1 entry0", v, 32'h0);

    // vector table walk
    for (int k = 0; k < 9; k++) begin
      int idx;
      logic [7:0] ent;
      logic [31:0] expCh;
      logic expErr;
      idx = int'(VEC[k][14:8]);
      ent = VEC[k][7:0];
      expCh = ent[7] ? (32'h1 << ent[4:0]) : 32'h0;
      expErr = ent[7] && (ent[4:0] >= 5'd24);
      busWr(entAddr(idx), {24'h0, ent}, err);
      chk("R10 mapErr on write", {31'h0, err}, {31'h0, expErr});
      busRd(entAddr(idx), v);
      chk((idx < 64) ? "R2 readback" : "R3 readback", v, {24'h0, ent});
      reqIn[idx] = 1'b1;
      @(negedge clk);
      chk("R4 no level after one edge", chReq, 32'h0);
      @(negedge clk);
      chk(ent[7] ? "R4 level" : "R5 invalid ignored", chReq, expCh);
      chk("R7 start pulse", chRasEvt, expCh);
      @(negedge clk);
      chk("R7 start pulse ends", chRasEvt, 32'h0);
      reqIn[idx] = 1'b0;
      waitN(2);
      chk("R8 level cleared", chReq, 32'h0);
      chk("R8 end pulse", chEorEvt, expCh);
      @(negedge clk);
      chk("R8 end pulse ends", chEorEvt, 32'h0);
      busWr(entAddr(idx), 32'h0, err);
    end

    // R6 shared channel, entries in both windows
    busWr(entAddr(1), 32'h89, err);
    busWr(entAddr(66), 32'h89, err);
    reqIn[1] = 1'b1;
    waitN(2);
    chk("R6 first request level", chReq, 32'h200);
    chk("R7 first start", chRasEvt, 32'h200);
    reqIn[66] = 1'b1;
    waitN(2);
    chk("R7 no start when already high", chRasEvt, 32'h0);
    chk("R6 level with both", chReq, 32'h200);
    reqIn[1] = 1'b0;
    waitN(2);
    chk("R6 level held by other", chReq, 32'h200);
    chk("R6 no end while other high", chEorEvt, 32'h0);
    reqIn[66] = 1'b0;
    waitN(2);
    chk("R6 level drops", chReq, 32'h0);
    chk("R8 end after last", chEorEvt, 32'h200);
    busWr(entAddr(1), 32'h0, err);
    busWr(entAddr(66), 32'h0, err);

    // R9 status words and stray addresses
    busWr(16'h00E0, 32'h0000_0083, err);
    busWr(16'h00E4, 32'h0000_0083, err);
    busWr(16'h0200, 32'h0000_0083, err);
    busRd(16'h00E0, v); chk("R9 status 0xE0", v, 32'h0);
    busRd(16'h00E4, v); chk("R9 status 0xE4", v, 32'h0);
    busRd(16'h00E8, v); chk("R9 status 0xE8", v, 32'h0);
    busRd(16'h0200, v); chk("R9 stray addr", v, 32'h0);
    busRd(16'h0100, v); chk("R9 entry0 untouched", v, 32'h0);
    reqIn[0] = 1'b1;
    waitN(2);
    chk("R9 no routing from status write", chReq, 32'h0);
    reqIn[0] = 1'b0;
    waitN(2);

    // R10 over-limit entry still stored and routed
    busWr(entAddr(20), 32'h9E, err);
    chk("R10 flag over limit", {31'h0, err}, 32'h1);
    @(negedge clk);
    chk("R10 flag one cycle", {31'h0, mapErr}, 32'h0);
    busRd(entAddr(20), v);
    chk("R10 stored", v, 32'h9E);
    reqIn[20] = 1'b1;
    waitN(2);
    chk("R10 routes", chReq, 32'h4000_0000);
    reqIn[20] = 1'b0;
    waitN(3);
    busWr(entAddr(21), 32'h0000_1085, err);
    chk("R10 reserved bits flagged", {31'h0, err}, 32'h1);
    busRd(entAddr(21), v);
    chk("R10 low byte stored", v, 32'h85);
    busWr(entAddr(22), 32'h97, err);
    chk("R10 channel 23 accepted", {31'h0, err}, 32'h0);

    // R5 invalid entry with channel bits at top window edge
    busWr(entAddr(74), 32'h1F, err);
    reqIn[74] = 1'b1;
    waitN(3);
    chk("R5 invalid top entry", chReq, 32'h0);
    chk("R5 no start", chRasEvt, 32'h0);
    reqIn[74] = 1'b0;
    waitN(2);

    summary();
  end
endmodule